// File: doc/BRIEF.md
# PC Card Slot Power and Address-Space Controller

This block is a small register file on a 16-bit host port. It turns two writable registers into the pin-level controls of a single PC card slot. The space register chooses which card address space later memory cycles reach: common memory, I/O or attribute/configuration. It also drives the active-low register-select strobe to match. The power register requests a Vcc level and switches Vpp between Vcc and ground. It also enables the Vcc-dependent outputs and controls the card reset line. A read-only identification register reports whether the block is the PC card variant or the expansion-bay variant.

Reads are combinational, so read data is valid in the same cycle that the word address is presented, with no wait states. Writes take effect on the next rising clock edge. The flag `vccGood` reports that Vcc is non-zero and that outputs are enabled. Status logic elsewhere uses it to decide when Vcc-dependent card pins can be trusted.

Top module: `card_slot_ctrl`

## Requirements
- R1: After reset, all writable bits are zero. So `vccSel`=00, `vppToVcc`=0, `outEnable`=0, `cardResetPin`=0, `spaceSel`=00 (common memory), `regStrobeN`=1 and `vccGood`=0.
- R2: A write to word address 0 stores `wrData[2:0]` in the space register. A read of address 0 returns those three bits in `rdData[2:0]`, with `rdData[15:3]` equal to zero.
- R3: Space bits [1:0] are decoded as follows. Code 00 gives `spaceSel`=00 (common) with `regStrobeN`=1. Code 01 gives `spaceSel`=01 (I/O) with `regStrobeN`=0. Codes 10 and 11 both give `spaceSel`=10 (configuration) with `regStrobeN`=0.
- R4: Space bit 2 is stored and read back, but it has no effect on `spaceSel` or `regStrobeN`.
- R5: Power bit 4 at word address 6 drives `vppToVcc`: 1 connects Vpp to Vcc, and 0 connects it to ground.
- R6: Power bits [3:2] select Vcc on `vccSel`. Code 01 gives `vccSel`=01 (3.3 V). Code 10 gives `vccSel`=10 (5 V). Codes 00 and 11 give `vccSel`=00 (0 V).
- R7: Power bit 1 drives `outEnable`.
- R8: `cardResetPin` is high only when power bit 0 is 0 and power bit 1 is 1. Otherwise it is low.
- R9: A read of address 6 returns the stored power bits in `rdData[4:0]`, with `rdData[15:5]` equal to zero.
- R10: A read of address 7 returns `ID_CODE` in `rdData[7:4]`, with all other bits zero. The default `ID_CODE` is 0010 (PC card variant); 0011 marks the expansion-bay variant. Writes to address 7 change no register.
- R11: `vccGood` is 1 exactly when `vccSel` is non-zero and `outEnable` is 1.
- R12: Reads of any other address return zero, and writes to them change no register.
- R13: `rdData` follows `addr` combinationally in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 3 | Word address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for `addr` |
| spaceSel | output | 2 | Selected card space: 00 common, 01 I/O, 10 configuration |
| regStrobeN | output | 1 | Register-select strobe level, low for I/O and configuration |
| vccSel | output | 2 | Requested Vcc: 00 off, 01 3.3 V, 10 5 V |
| vppToVcc | output | 1 | 1 connects Vpp to Vcc, 0 connects it to ground |
| outEnable | output | 1 | Enable for the Vcc-dependent outputs |
| cardResetPin | output | 1 | Card reset line level (high means driven to Vcc) |
| vccGood | output | 1 | Vcc on and outputs enabled |

## Verification
The hardest cases to reach are the combinations in which one power field silently cancels another. Examples are a reset-release request while outputs are disabled, or an enable with the reserved Vcc code 11, which must read as 0 V. The stimulus table walks the power register through such values in turn, and the space register through all four codes with bit 2 toggled. Writes with all bits set land on the space, power, identification and unmapped addresses; each is followed by a readback that shows only the kept bits changed. A reset pulse in the middle of the run then confirms that every control returns to its safe level.

// File: rtl/cslot_pkg.sv
package cslot_pkg;
  typedef enum logic [1:0] {
    SPACE_COMMON = 2'b00,
    SPACE_IO     = 2'b01,
    SPACE_CONFIG = 2'b10
  } spaceKind_e;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_SPACE = 2'd1,
    RD_POWER = 2'd2,
    RD_ID    = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrSpace;
    logic   wrPower;
    rdSel_e rdSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/cslot_ctrl.sv
module cslot_ctrl
  import cslot_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int SPACE_ADDR = 0,
  parameter int POWER_ADDR = 6,
  parameter int ID_ADDR    = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStrobes_t      strb
);
  always_comb begin
    strb.wrSpace = wrEn && (addr == ADDR_W'(SPACE_ADDR));
    strb.wrPower = wrEn && (addr == ADDR_W'(POWER_ADDR));
    if (addr == ADDR_W'(SPACE_ADDR))      strb.rdSel = RD_SPACE;
    else if (addr == ADDR_W'(POWER_ADDR)) strb.rdSel = RD_POWER;
    else if (addr == ADDR_W'(ID_ADDR))    strb.rdSel = RD_ID;
    else                                  strb.rdSel = RD_NONE;
  end

  // R12: at most one register is written per cycle
  assert_one_write_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrSpace, strb.wrPower}));
  // R10: the identification address never produces a write strobe
  assert_id_readonly_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == RD_ID) |-> !(strb.wrSpace || strb.wrPower));
endmodule

// File: rtl/cslot_datapath.sv
module cslot_datapath
  import cslot_pkg::*;
#(
  parameter int         DATA_W  = 16,
  parameter logic [3:0] ID_CODE = 4'b0010
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        spaceSel,
  output logic              regStrobeN,
  output logic [1:0]        vccSel,
  output logic              vppToVcc,
  output logic              outEnable,
  output logic              cardResetPin,
  output logic              vccGood
);
  localparam int SPACE_KEEP = 3;
  localparam int POWER_KEEP = 5;
  localparam int ID_LSB     = 4;

  logic [SPACE_KEEP-1:0] spaceReg;
  logic [POWER_KEEP-1:0] powerReg;
  logic                  unusedHiBits;

  assign unusedHiBits = ^wrData[DATA_W-1:POWER_KEEP];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spaceReg <= '0;
      powerReg <= '0;
    end else begin
      if (strb.wrSpace) spaceReg <= wrData[SPACE_KEEP-1:0];
      if (strb.wrPower) powerReg <= wrData[POWER_KEEP-1:0];
    end
  end

  // space decode: bit 2 is deliberately ignored
  always_comb begin
    unique case (spaceReg[1:0])
      2'b00:   spaceSel = SPACE_COMMON;
      2'b01:   spaceSel = SPACE_IO;
      default: spaceSel = SPACE_CONFIG;
    endcase
    regStrobeN = (spaceReg[1:0] == 2'b00);
  end

  // power decode
  always_comb begin
    unique case (powerReg[3:2])
      2'b01:   vccSel = 2'b01;
      2'b10:   vccSel = 2'b10;
      default: vccSel = 2'b00;
    endcase
    vppToVcc     = powerReg[4];
    outEnable    = powerReg[1];
    cardResetPin = powerReg[1] && !powerReg[0];
    vccGood      = powerReg[1] && (vccSel != 2'b00);
  end

  always_comb begin
    rdData = '0;
    unique case (strb.rdSel)
      RD_SPACE: rdData[SPACE_KEEP-1:0] = spaceReg;
      RD_POWER: rdData[POWER_KEEP-1:0] = powerReg;
      RD_ID:    rdData[ID_LSB+3:ID_LSB] = ID_CODE;
      default:  rdData = '0;
    endcase
  end

  assert_space_store_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSpace |=> spaceReg == $past(wrData[SPACE_KEEP-1:0]));
  assert_power_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrPower |=> $stable(powerReg));
  assert_reg_level_R3: assert property (@(posedge clk) disable iff (!rstN)
    regStrobeN == (spaceSel == SPACE_COMMON));
  assert_vcc_legal_R6: assert property (@(posedge clk) disable iff (!rstN)
    vccSel != 2'b11);
  assert_reset_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    cardResetPin |-> outEnable);
  assert_good_flag_R11: assert property (@(posedge clk) disable iff (!rstN)
    vccGood |-> (outEnable && vccSel != 2'b00));
endmodule

// File: rtl/card_slot_ctrl.sv
module card_slot_ctrl
  import cslot_pkg::*;
#(
  parameter int         DATA_W     = 16,
  parameter int         ADDR_W     = 3,
  parameter int         SPACE_ADDR = 0,
  parameter int         POWER_ADDR = 6,
  parameter int         ID_ADDR    = 7,
  parameter logic [3:0] ID_CODE    = 4'b0010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        spaceSel,
  output logic              regStrobeN,
  output logic [1:0]        vccSel,
  output logic              vppToVcc,
  output logic              outEnable,
  output logic              cardResetPin,
  output logic              vccGood
);
  ctrlStrobes_t strb;

  cslot_ctrl #(
    .ADDR_W(ADDR_W), .SPACE_ADDR(SPACE_ADDR),
    .POWER_ADDR(POWER_ADDR), .ID_ADDR(ID_ADDR)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .strb(strb)
  );

  cslot_datapath #(.DATA_W(DATA_W), .ID_CODE(ID_CODE)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rdData(rdData),
    .spaceSel(spaceSel), .regStrobeN(regStrobeN), .vccSel(vccSel),
    .vppToVcc(vppToVcc), .outEnable(outEnable),
    .cardResetPin(cardResetPin), .vccGood(vccGood)
  );
endmodule

// File: tb/sim_card_slot_ctrl.sv
module sim_card_slot_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;
  // vector: addr(3) data(16) expected rdData(16) expected outputs(9)
  // outputs = {regStrobeN, spaceSel[1:0], vccSel[1:0], vppToVcc, outEnable, cardResetPin, vccGood}
  localparam logic [43:0] VEC [NVEC] = '{
    {3'd0, 16'hFFFF, 16'h0007, 9'b0_10_00_0000}, // R2 R3 code 11 -> config
    {3'd0, 16'h0001, 16'h0001, 9'b0_01_00_0000}, // R3 io
    {3'd0, 16'h0004, 16'h0004, 9'b1_00_00_0000}, // R4 bit2 no effect, common
    {3'd0, 16'h0002, 16'h0002, 9'b0_10_00_0000}, // R3 code 10 -> config
    {3'd6, 16'h0006, 16'h0006, 9'b0_10_01_0111}, // R6 3V3, R7, R8, R11
    {3'd6, 16'hFFEB, 16'h000B, 9'b0_10_10_0101}, // R9 R6 5V, R8 held low by bit0
    {3'd6, 16'h001D, 16'h001D, 9'b0_10_00_1000}, // R5 R6 code 11 -> off
    {3'd6, 16'h0012, 16'h0012, 9'b0_10_00_1110}, // R11 no Vcc -> not good
    {3'd6, 16'h0000, 16'h0000, 9'b0_10_00_0000}, // R5 R7
    {3'd6, 16'h0008, 16'h0008, 9'b0_10_10_0000}, // R8 R11 enable off
    {3'd7, 16'hFFFF, 16'h0020, 9'b0_10_10_0000}, // R10 id read, write ignored
    {3'd3, 16'hFFFF, 16'h0000, 9'b0_10_10_0000}, // R12 unmapped
    {3'd0, 16'h0000, 16'h0000, 9'b1_00_10_0000}  // R3 back to common
  };

  logic clk = 0, rstN = 0, wrEn = 0;
  logic [2:0] addr = '0;
  logic [15:0] wrData = '0, rdData;
  logic [1:0] spaceSel, vccSel;
  logic regStrobeN, vppToVcc, outEnable, cardResetPin, vccGood;
  int checks = 0, errors = 0;
  bit done = 0;

  card_slot_ctrl u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .spaceSel(spaceSel), .regStrobeN(regStrobeN),
    .vccSel(vccSel), .vppToVcc(vppToVcc), .outEnable(outEnable),
    .cardResetPin(cardResetPin), .vccGood(vccGood)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [8:0] outs();
    return {regStrobeN, spaceSel, vccSel, vppToVcc, outEnable, cardResetPin, vccGood};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rd(input logic [2:0] a, input string req, input logic [15:0] exp);
    addr = a; #1;
    check(req, rdData, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", 16'(outs()), 16'(9'b1_00_00_0000));
    rstN = 1;
    @(negedge clk);
    rd(3'd0, "R1 space reads zero", 16'h0000);
    rd(3'd6, "R1 power reads zero", 16'h0000);
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][43:41], VEC[i][40:25]);
      rd(VEC[i][43:41], $sformatf("R2-vector %0d readback", i), VEC[i][24:9]);
      check($sformatf("R3 R6 R8 vector %0d outputs", i), 16'(outs()), 16'(VEC[i][8:0]));
    end
    // R10 and R12: earlier writes to 7 and 3 left the power register untouched
    rd(3'd6, "R12 power kept after stray writes", 16'h0008);
    rd(3'd7, "R10 id stable", 16'h0020);
    // R13: read data changes with addr alone, no clock edge in between
    @(posedge clk); #2;
    rd(3'd0, "R13 comb read space", 16'h0000);
    rd(3'd6, "R13 comb read power", 16'h0008);
    // R1: mid-run reset returns all controls to safe levels
    wr(3'd0, 16'h0003);
    wr(3'd6, 16'h0016);
    check("R8 reset released", 16'(cardResetPin), 16'h0001);
    #1 rstN = 0; #1;
    check("R1 async reset outputs", 16'(outs()), 16'(9'b1_00_00_0000));
    rd(3'd6, "R1 power cleared", 16'h0000);
    done = 1;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
  end

  initial begin
    wait (done || $time > 2000 * CLK_PERIOD);
    #1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule